// File: doc/BRIEF.md
# Compressor Energy Estimation Filter Chain

This block prepares the signals that a dynamic range compressor needs to estimate how loud the audio is. Each incoming signed sample first passes through a first-order high-pass section, which removes DC and very low frequencies. The high-pass result then passes through a first-order low-pass section, which smooths it. The high-pass result leaves the block as the filtered audio for the downstream processing path. The magnitude of the low-pass result leaves as the energy estimate.

Both sections use the same recurrence, normalised by 2^15: y[n] = (N0·x[n] + N1·x[n−1] + D1·y[n−1]) / 2^15. Each section has its own three 16-bit two's-complement coefficients. Software loads them one byte at a time through a plain address/data/write-enable port. A coefficient only changes once its whole 16-bit value is present, so the filters never run with a half-written coefficient. Reset clears the filter history and loads a high-pass default set and a low-pass default set.

Top module: `est_filter_chain`

## Requirements
- R1: For each section, on an accepted sample the block forms acc = N0·x[n] + N1·x[n−1] + D1·y[n−1] exactly, then computes (acc + 2^14) >>> 15 (arithmetic shift), saturates it to [−32768, 32767] and keeps the result as that section's y[n] (the next y[n−1]).
- R2: The input sample drives the high-pass section. The saturated high-pass y[n] is the low-pass section's x[n]. `hp_out` carries the high-pass y[n].
- R3: `energy_out` is the absolute value of the low-pass y[n]. A low-pass value of −32768 gives 32767.
- R4: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high. `hp_out` and `energy_out` change only on the edge that raises such a result and hold their value otherwise.
- R5: When `in_valid` is low, neither section's x[n−1] or y[n−1] changes.
- R6: Coefficient address map, byte-wide: address 2k holds the high byte [15:8] and address 2k+1 holds the low byte [7:0] of coefficient k. The order of k is 0 HP N0, 1 HP N1, 2 HP D1, 3 LP N0, 4 LP N1, 5 LP D1.
- R7: A write to an even (high-byte) address only stages the byte. The coefficient used by the filter does not change.
- R8: A write to an odd (low-byte) address commits {staged high byte, written byte} as the new coefficient at that clock edge. A sample accepted in the same cycle still uses the previous value.
- R9: While `rst_n` is low, both sections' histories clear, `out_valid`, `hp_out` and `energy_out` are 0, and the coefficients load the defaults HP N0=0x7F56, HP N1=0x80AA, HP D1=0x7EAC, LP N0=0x0022, LP N1=0x0022, LP D1=0x7FBC. Each staged high byte loads the high byte of its coefficient's default.
- R10: Writes to addresses 12 to 15 change no coefficient and no staged byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 16 | Signed input sample |
| cfg_we | input | 1 | Coefficient byte write enable |
| cfg_addr | input | 4 | Coefficient byte address |
| cfg_wdata | input | 8 | Coefficient byte data |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| hp_out | output | 16 | Signed high-pass result for the audio path |
| energy_out | output | 16 | Magnitude of the low-pass result |

## Verification
A coefficient low-byte commit can land in the same cycle as an accepted sample. The bench provokes this by driving `cfg_we` on an odd address together with `in_valid`. It judges the output of that sample against a model that still uses the previous coefficient, and it judges the following sample against the new coefficient. A staged high byte with no matching low byte is also driven alongside samples, and the bench checks that the outputs stay on the old response.

// File: rtl/est_pkg.sv
package est_pkg;
  localparam int NCOEF = 6;
  localparam int K_HP_N0 = 0;
  localparam int K_HP_N1 = 1;
  localparam int K_HP_D1 = 2;
  localparam int K_LP_N0 = 3;
  localparam int K_LP_N1 = 4;
  localparam int K_LP_D1 = 5;
  localparam int FRAC = 15;

  // Default coefficients: high-pass near 0.00166 fs, low-pass near 0.00033 fs
  function automatic logic [15:0] coef_default(input int k);
    case (k)
      K_HP_N0: coef_default = 16'h7F56;
      K_HP_N1: coef_default = 16'h80AA;
      K_HP_D1: coef_default = 16'h7EAC;
      K_LP_N0: coef_default = 16'h0022;
      K_LP_N1: coef_default = 16'h0022;
      default: coef_default = 16'h7FBC;
    endcase
  endfunction
endpackage

// File: rtl/est_coef_bank.sv
module est_coef_bank
  import est_pkg::*;
#(
  parameter int CW = 16,
  parameter int AW = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [AW-1:0]            addr,
  input  logic [CW/2-1:0]          wdata,
  output logic [NCOEF-1:0][CW-1:0] coef
);
  localparam int BW = CW / 2;

  logic [NCOEF-1:0][BW-1:0] stage_q, stage_d;
  logic [NCOEF-1:0][CW-1:0] coef_q, coef_d;
  logic [NCOEF-1:0]         hit_hi, hit_lo;

  for (genvar k = 0; k < NCOEF; k++) begin : g_coef
    assign hit_hi[k] = we && (addr == AW'(2 * k));
    assign hit_lo[k] = we && (addr == AW'(2 * k + 1));

    always_comb begin
      stage_d[k] = stage_q[k];
      coef_d[k]  = coef_q[k];
      if (hit_hi[k]) stage_d[k] = wdata;
      if (hit_lo[k]) coef_d[k]  = {stage_q[k], wdata};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[k] <= BW'(coef_default(k) >> BW);
        coef_q[k]  <= CW'(coef_default(k));
      end else begin
        stage_q[k] <= stage_d[k];
        coef_q[k]  <= coef_d[k];
      end
    end

    p_hi_no_effect_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hit_hi[k] |=> $stable(coef_q[k]));
    p_lo_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hit_lo[k] |=> coef_q[k] == {$past(stage_q[k]), $past(wdata)});
  end

  assign coef = coef_q;
endmodule

// File: rtl/est_iir1.sv
module est_iir1
  import est_pkg::*;
#(
  parameter int SW = 16,
  parameter int CW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_vld,
  input  logic signed [SW-1:0] x,
  input  logic signed [CW-1:0] n0,
  input  logic signed [CW-1:0] n1,
  input  logic signed [CW-1:0] d1,
  output logic signed [SW-1:0] y
);
  localparam int PW   = SW + CW;
  localparam int ACCW = PW + 2;
  localparam logic [ACCW-1:0] HALF = ACCW'(1) << (FRAC - 1);

  logic signed [SW-1:0] x1_q, x1_d, y1_q, y1_d;
  logic signed [PW-1:0] pr0, pr1, pr2;
  logic [ACCW-1:0]      acc, rnd;
  logic signed [ACCW-1:0] shf;
  logic                 in_range;

  assign pr0 = n0 * x;
  assign pr1 = n1 * x1_q;
  assign pr2 = d1 * y1_q;

  always_comb begin
    acc = {{(ACCW-PW){pr0[PW-1]}}, pr0}
        + {{(ACCW-PW){pr1[PW-1]}}, pr1}
        + {{(ACCW-PW){pr2[PW-1]}}, pr2};
    rnd = acc + HALF;
    shf = $signed(rnd) >>> FRAC;
    in_range = (shf[ACCW-1:SW-1] == '0) || (shf[ACCW-1:SW-1] == '1);
    if (in_range)          y = shf[SW-1:0];
    else if (shf[ACCW-1])  y = {1'b1, {(SW-1){1'b0}}};
    else                   y = {1'b0, {(SW-1){1'b1}}};
  end

  always_comb begin
    x1_d = x1_q;
    y1_d = y1_q;
    if (smp_vld) begin
      x1_d = x;
      y1_d = y;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x1_q <= '0;
      y1_q <= '0;
    end else begin
      x1_q <= x1_d;
      y1_q <= y1_d;
    end
  end

  p_state_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(x1_q) && $stable(y1_q));
endmodule

// File: rtl/est_mag.sv
module est_mag #(
  parameter int SW = 16
) (
  input  logic signed [SW-1:0] val,
  output logic        [SW-1:0] mag
);
  localparam logic [SW-1:0] MINV = {1'b1, {(SW-1){1'b0}}};
  localparam logic [SW-1:0] MAXV = {1'b0, {(SW-1){1'b1}}};

  always_comb begin
    if (val == MINV)  mag = MAXV;
    else if (val[SW-1]) mag = -val;
    else              mag = val;
  end
endmodule

// File: rtl/est_filter_chain.sv
module est_filter_chain
  import est_pkg::*;
#(
  parameter int SW = 16,
  parameter int CW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [SW-1:0] in_sample,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [CW/2-1:0] cfg_wdata,
  output logic          out_valid,
  output logic [SW-1:0] hp_out,
  output logic [SW-1:0] energy_out
);
  logic [NCOEF-1:0][CW-1:0] coef;
  logic signed [SW-1:0] hp_y, lp_y;
  logic [SW-1:0]        lp_mag;
  logic                 vld_q, vld_d;
  logic [SW-1:0]        hp_q, hp_d, en_q, en_d;

  est_coef_bank #(.CW(CW), .AW(AW)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .coef(coef)
  );

  est_iir1 #(.SW(SW), .CW(CW)) u_hp (
    .clk(clk), .rst_n(rst_n), .smp_vld(in_valid), .x(in_sample),
    .n0(coef[K_HP_N0]), .n1(coef[K_HP_N1]), .d1(coef[K_HP_D1]), .y(hp_y)
  );

  est_iir1 #(.SW(SW), .CW(CW)) u_lp (
    .clk(clk), .rst_n(rst_n), .smp_vld(in_valid), .x(hp_y),
    .n0(coef[K_LP_N0]), .n1(coef[K_LP_N1]), .d1(coef[K_LP_D1]), .y(lp_y)
  );

  est_mag #(.SW(SW)) u_mag (.val(lp_y), .mag(lp_mag));

  always_comb begin
    vld_d = in_valid;
    hp_d  = hp_q;
    en_d  = en_q;
    if (in_valid) begin
      hp_d = hp_y;
      en_d = lp_mag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      hp_q  <= '0;
      en_q  <= '0;
    end else begin
      vld_q <= vld_d;
      hp_q  <= hp_d;
      en_q  <= en_d;
    end
  end

  assign out_valid  = vld_q;
  assign hp_out     = hp_q;
  assign energy_out = en_q;

  p_valid_lat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(hp_out) && $stable(energy_out));
endmodule

// File: tb/est_filter_chain_bench.sv
`timescale 1ns/1ps
module est_filter_chain_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic [15:0] in_sample;
  logic cfg_we;
  logic [3:0] cfg_addr;
  logic [7:0] cfg_wdata;
  logic out_valid;
  logic [15:0] hp_out, energy_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int cm[6];
  int stg[6];
  int hx1, hy1, lx1, ly1;
  int exp_hp, exp_en;

  always #2 clk = ~clk;

  est_filter_chain u_est_filter_chain (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .out_valid(out_valid), .hp_out(hp_out), .energy_out(energy_out)
  );

  function automatic int s16(input int v);
    int u;
    u = v & 32'hFFFF;
    return (u >= 32768) ? u - 65536 : u;
  endfunction

  function automatic int sec(input int n0, input int n1, input int d1,
                             input int x, input int x1, input int y1);
    longint acc, r;
    acc = longint'(n0) * x + longint'(n1) * x1 + longint'(d1) * y1;
    r = (acc + 16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    int d[6] = '{32598, -32598, 32428, 34, 34, 32700};
    foreach (d[k]) begin
      cm[k] = d[k];
      stg[k] = (d[k] >> 8) & 8'hFF;
    end
    hx1 = 0; hy1 = 0; lx1 = 0; ly1 = 0;
  endtask

  // One clock: drive at negedge, model, then check at the next negedge
  task automatic step(input bit v, input int x, input bit we, input int a,
                      input int d, input string req);
    int hp, lp, ph, pe;
    ph = s16(hp_out); pe = energy_out;
    in_valid = v; in_sample = 16'(x); cfg_we = we; cfg_addr = 4'(a); cfg_wdata = 8'(d);
    if (v) begin
      hp = sec(cm[0], cm[1], cm[2], x, hx1, hy1);
      lp = sec(cm[3], cm[4], cm[5], hp, lx1, ly1);
      hx1 = x; hy1 = hp; lx1 = hp; ly1 = lp;
      exp_hp = hp;
      exp_en = (lp == -32768) ? 32767 : ((lp < 0) ? -lp : lp);
    end
    if (we && a < 12) begin
      if (a % 2 == 0) stg[a/2] = d & 8'hFF;
      else cm[a/2] = s16((stg[a/2] << 8) | (d & 8'hFF));
    end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; cfg_we = 1'b0;
    chk({req, " out_valid"}, int'(out_valid), int'(v));
    if (v) begin
      chk({req, " hp_out"}, s16(hp_out), exp_hp);
      chk({req, " energy_out"}, int'(energy_out), exp_en);
    end else begin
      chk({req, " hp_out hold"}, s16(hp_out), ph);
      chk({req, " energy_out hold"}, int'(energy_out), pe);
    end
  endtask

  task automatic wr16(input int k, input int val, input string req);
    step(1'b0, 0, 1'b1, 2 * k, (val >> 8) & 8'hFF, req);
    step(1'b0, 0, 1'b1, 2 * k + 1, val & 8'hFF, req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0; in_sample = '0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R9 out_valid after reset", int'(out_valid), 0);
    chk("R9 hp_out after reset", int'(hp_out), 0);
    chk("R9 energy_out after reset", int'(energy_out), 0);
  endtask

  task automatic t_default_step();
    for (int i = 0; i < 24; i++) step(1'b1, 12000, 1'b0, 0, 0, "R1 R2 R3 R9 default step");
    for (int i = 0; i < 8; i++) step(1'b1, -9000 + i * 700, 1'b0, 0, 0, "R1 R2 ramp");
  endtask

  task automatic t_program();
    wr16(0, 16'h4000, "R6 write");
    wr16(1, 16'h2000, "R6 write");
    wr16(2, 16'h1000, "R6 write");
    wr16(3, 16'h6000, "R6 write");
    wr16(4, 16'hE000, "R6 write");
    wr16(5, 16'hC000, "R6 write");
    for (int i = 0; i < 10; i++)
      step(1'b1, (i % 2 == 0) ? 20000 - i * 1500 : -15000 + i * 900, 1'b0, 0, 0, "R1 R2 R6 programmed");
  endtask

  task automatic t_high_only();
    step(1'b0, 0, 1'b1, 0, 8'h11, "R7 stage high");
    for (int i = 0; i < 4; i++) step(1'b1, 7000 * (i + 1), 1'b0, 0, 0, "R7 old coefficient kept");
    step(1'b1, 3000, 1'b1, 2, 8'h22, "R7 stage with sample");
    step(1'b1, -3000, 1'b0, 0, 0, "R7 old coefficient kept");
  endtask

  task automatic t_same_cycle();
    step(1'b0, 0, 1'b1, 0, 8'h7F, "R8 stage");
    step(1'b1, 16000, 1'b1, 1, 8'hFF, "R8 commit with sample uses old");
    step(1'b1, 16000, 1'b0, 0, 0, "R8 next sample uses new");
    step(1'b1, -8000, 1'b1, 11, 8'h00, "R8 commit LP D1 low with sample");
    step(1'b1, -8000, 1'b0, 0, 0, "R8 next sample uses new");
  endtask

  task automatic t_gap();
    step(1'b1, 5000, 1'b0, 0, 0, "R4 before gap");
    for (int i = 0; i < 5; i++) step(1'b0, 31000, 1'b0, 0, 0, "R4 R5 idle hold");
    step(1'b1, 5000, 1'b0, 0, 0, "R5 history kept across gap");
    step(1'b1, -5000, 1'b0, 0, 0, "R5 history kept across gap");
  endtask

  task automatic t_bad_addr();
    for (int a = 12; a < 16; a++) step(1'b0, 0, 1'b1, a, 8'hA5, "R10 ignored write");
    step(1'b0, 0, 1'b1, 7, 8'h40, "R10 commit LP N0 low byte");
    for (int i = 0; i < 3; i++) step(1'b1, 9000, 1'b0, 0, 0, "R10 coefficients intact");
  endtask

  task automatic t_saturate();
    for (int k = 0; k < 6; k++) wr16(k, (k == 2 || k == 5) ? 0 : 16'h7FFF, "R1 sat setup");
    for (int i = 0; i < 3; i++) step(1'b1, 32767, 1'b0, 0, 0, "R1 positive saturation");
    for (int i = 0; i < 3; i++) step(1'b1, -32768, 1'b0, 0, 0, "R1 R3 negative saturation");
  endtask

  task automatic t_reset_mid();
    step(1'b1, 1234, 1'b0, 0, 0, "R9 before reset");
    do_reset();
    chk("R9 hp_out cleared", int'(hp_out), 0);
    chk("R9 energy_out cleared", int'(energy_out), 0);
    for (int i = 0; i < 6; i++) step(1'b1, 20000, 1'b0, 0, 0, "R9 defaults reloaded");
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0; in_sample = '0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    t_reset();
    t_default_step();
    t_program();
    t_high_only();
    t_same_cycle();
    t_gap();
    t_bad_addr();
    t_saturate();
    t_reset_mid();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule